// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block is a synchronous timekeeping core. A one-cycle enable at 100 Hz advances it. It keeps every field in packed BCD: hundredths of a second, seconds, minutes, hours, weekday, day of the month, month and a two-digit year. The hours byte carries its own format bit, which selects a 24-hour count or a 12-hour count with an afternoon flag. Month lengths, including February in leap years, are worked out from the stored month and year. A stop bit in the weekday byte freezes all counting, so software can set the time while the clock is halted.

The eight bytes are exposed as one flat bus, with register k on bits [8k+7:8k]. A single strobe writes all eight at once. Register 0 holds tenths in its upper nibble and hundredths in its lower nibble. Registers 1 and 2 hold seconds and minutes. Register 3 is hours, register 4 is weekday with the stop bit, register 5 is the date, register 6 is the month and register 7 is the year. Loaded values are assumed to be valid BCD within each field's range.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the bus reads 64'h0001_0121_0000_0000. That is 00:00:00.00 in 24-hour mode, weekday 1 with the stop bit set (register 4 = 8'h21), date 01, month 01 and year 00.
- R2: Register 0 counts 00 to 99 in BCD, advancing by one on each counted tick. When it wraps from 99 to 00, seconds advance by one.
- R3: Seconds and minutes each count 00 to 59 in BCD. A wrap to 00 carries into the next field.
- R4: With bit 7 of register 3 at 0, hours count 00 to 23. Bit 5 is the second tens bit, so 19 steps to 20. A wrap from 23 to 00 advances the day.
- R5: With bit 7 of register 3 at 1, bits 4:0 hold hours 01 to 12 and bit 5 is the afternoon flag (1 = PM). Hour 11 steps to 12 and toggles the flag. Hour 12 steps to 01 without toggling it. The day advances only on the step from PM 11 to AM 12.
- R6: The weekday, bits 2:0 of register 4, counts 1 to 7 and wraps from 7 to 1 when the day advances.
- R7: The date wraps to 01 and the month advances after day 30 of April, June, September and November, after day 31 of the other long months, and after day 28 of February in a year that is not a leap year.
- R8: A year whose value is divisible by 4, including 00, is a leap year. In a leap year February ends after day 29.
- R9: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R10: While bit 5 of register 4 is 1, a tick changes nothing on the bus. While it is 0, every tick advances the count.
- R11: These bits always read 0, whatever was loaded: bit 7 of registers 1 and 2; bit 6 of register 3; bits 7, 6, 4 and 3 of register 4; bits 7:6 of register 5; bits 7:5 of register 6.
- R12: A load takes priority over a tick in the same cycle. The loaded value, with the bits of R11 cleared, is on the bus after that clock edge.
- R13: In a cycle with neither tick nor load, the bus holds its value.
- R14: A single tick ripples the carry from hundredths through to the year. For example, 99-12-31 23:59:59.99 with weekday 7 becomes 00-01-01 00:00:00.00 with weekday 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 100 Hz advance enable, one cycle wide |
| load | input | 1 | Parallel write strobe for all registers |
| load_data | input | 64 | Register values to write, register k on bits [8k+7:8k] |
| time_out | output | 64 | Current register values, same layout |

## Verification
The bench builds the block with its default parameters: eight 8-bit registers and the every-fourth-year leap rule enabled. That is the only configuration in which the register layout, the leap-day path and the four-year leap rule can be observed. With those defaults the bench can load any calendar moment directly, so single ticks reach every month-end length, the leap and non-leap Februaries, the year and century wraps, and both hour formats, including the afternoon flag. There is no need to wait through long counting runs.

// File: rtl/bcd_calendar_pkg.sv
package bcd_calendar_pkg;
   localparam int unsigned CAL_NREG  = 8;
   localparam int unsigned CAL_REG_W = 8;

   typedef logic [CAL_REG_W-1:0] bcd_byte_t;

   // Bits that hold state; every other bit reads as zero
   localparam logic [63:0] CAL_LIVE_MASK = 64'hFF1F_3F27_BF7F_7FFF;

   // Default moment after reset
   localparam bcd_byte_t RST_HUND = 8'h00;
   localparam bcd_byte_t RST_SEC  = 8'h00;
   localparam bcd_byte_t RST_MIN  = 8'h00;
   localparam bcd_byte_t RST_DOW  = 8'h01;
   localparam bcd_byte_t RST_DATE = 8'h01;
   localparam bcd_byte_t RST_MON  = 8'h01;
   localparam bcd_byte_t RST_YEAR = 8'h00;
   localparam logic      RST_STOP = 1'b1;
endpackage

// File: rtl/bcd2_step.sv
module bcd2_step (
   input  logic [7:0] cur,
   input  logic [7:0] lo,
   input  logic [7:0] hi,
   output logic [7:0] nxt,
   output logic       wrap
);
   always_comb begin
      wrap = (cur == hi);
      if (wrap)
         nxt = lo;
      else if (cur[3:0] == 4'd9)
         nxt = {cur[7:4] + 4'd1, 4'd0};
      else
         nxt = {cur[7:4], cur[3:0] + 4'd1};
   end
endmodule

// File: rtl/cal_hour_step.sv
module cal_hour_step (
   input  logic       mode12,
   input  logic       b5,
   input  logic [4:0] low5,
   output logic       nb5,
   output logic [4:0] nlow5,
   output logic       day_roll
);
   logic [7:0] h24, h12, n24, n12;
   logic       w24, w12, at11;
   logic       unused_hi;

   assign h24 = {2'b00, b5, low5};
   assign h12 = {3'b000, low5};

   bcd2_step u_h24 (.cur(h24), .lo(8'h00), .hi(8'h23), .nxt(n24), .wrap(w24));
   bcd2_step u_h12 (.cur(h12), .lo(8'h01), .hi(8'h12), .nxt(n12), .wrap(w12));

   assign at11      = (h12 == 8'h11);
   assign unused_hi = ^{n24[7:6], n12[7:5], w12};

   always_comb begin
      if (mode12) begin
         nlow5    = n12[4:0];
         nb5      = b5 ^ at11;
         day_roll = at11 & b5;
      end else begin
         nlow5    = n24[4:0];
         nb5      = n24[5];
         day_roll = w24;
      end
   end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len #(
   parameter bit LEAP_EN = 1'b1
) (
   input  logic [7:0] mon,
   input  logic [7:0] yr,
   output logic [7:0] last
);
   logic       leap;
   logic [4:0] mon_bin;

   assign mon_bin = (mon[4] ? 5'd10 : 5'd0) + {1'b0, mon[3:0]};

   generate
      if (LEAP_EN) begin : g_leap4
         logic [7:0] yr_bin;
         assign yr_bin = ({1'b0, yr[7:4], 3'b000}) + ({3'b000, yr[7:4], 1'b0}) + {4'b0000, yr[3:0]};
         assign leap   = (yr_bin[1:0] == 2'b00);
      end else begin : g_noleap
         logic unused_yr;
         assign unused_yr = ^yr;
         assign leap      = 1'b0;
      end
   endgenerate

   always_comb begin
      case (mon_bin)
         5'd2:                    last = leap ? 8'h29 : 8'h28;
         5'd4, 5'd6, 5'd9, 5'd11: last = 8'h30;
         default:                 last = 8'h31;
      endcase
   end
endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
   import bcd_calendar_pkg::*;
#(
   parameter int unsigned NREG    = CAL_NREG,
   parameter int unsigned REG_W   = CAL_REG_W,
   parameter bit          LEAP_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic                    load,
   input  logic [NREG*REG_W-1:0]   load_data,
   output logic [NREG*REG_W-1:0]   time_out
);
   localparam int unsigned BUS_W = NREG * REG_W;

   generate
      if (NREG != 8) begin : g_bad_nreg
         $error("bcd_calendar_core: NREG must be 8");
      end
      if (REG_W != 8) begin : g_bad_regw
         $error("bcd_calendar_core: REG_W must be 8");
      end
   endgenerate

   bcd_byte_t hund, sec, mins, dow, date, mon, yr;
   logic      hmode, hb5, stop;
   logic [4:0] hlow;

   bcd_byte_t n_hund, n_sec, n_min, n_dow, n_date, n_mon, n_yr, last_day;
   logic      w_hund, w_sec, w_min, w_dow, w_date, w_mon, w_yr;
   logic      n_hb5, hr_roll;
   logic [4:0] n_hlow;
   logic      run, c_sec, c_min, c_hr, c_day, c_mon, c_yr;
   logic      unused_bits;

   bcd2_step u_hund (.cur(hund), .lo(8'h00), .hi(8'h99), .nxt(n_hund), .wrap(w_hund));
   bcd2_step u_sec  (.cur(sec),  .lo(8'h00), .hi(8'h59), .nxt(n_sec),  .wrap(w_sec));
   bcd2_step u_min  (.cur(mins), .lo(8'h00), .hi(8'h59), .nxt(n_min),  .wrap(w_min));
   bcd2_step u_dow  (.cur(dow),  .lo(8'h01), .hi(8'h07), .nxt(n_dow),  .wrap(w_dow));
   bcd2_step u_date (.cur(date), .lo(8'h01), .hi(last_day), .nxt(n_date), .wrap(w_date));
   bcd2_step u_mon  (.cur(mon),  .lo(8'h01), .hi(8'h12), .nxt(n_mon),  .wrap(w_mon));
   bcd2_step u_yr   (.cur(yr),   .lo(8'h00), .hi(8'h99), .nxt(n_yr),   .wrap(w_yr));

   cal_hour_step u_hour (
      .mode12(hmode), .b5(hb5), .low5(hlow),
      .nb5(n_hb5), .nlow5(n_hlow), .day_roll(hr_roll)
   );

   cal_month_len #(.LEAP_EN(LEAP_EN)) u_mlen (.mon(mon), .yr(yr), .last(last_day));

   // Carry chain: all fields settle within one tick
   assign run   = tick & ~stop;
   assign c_sec = run   & w_hund;
   assign c_min = c_sec & w_sec;
   assign c_hr  = c_min & w_min;
   assign c_day = c_hr  & hr_roll;
   assign c_mon = c_day & w_date;
   assign c_yr  = c_mon & w_mon;

   assign unused_bits = ^{load_data[15], load_data[23], load_data[30],
                          load_data[39:38], load_data[36:35],
                          load_data[47:46], load_data[55:53], w_dow, w_yr};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hund  <= RST_HUND;
         sec   <= RST_SEC;
         mins  <= RST_MIN;
         hmode <= 1'b0;
         hb5   <= 1'b0;
         hlow  <= 5'd0;
         stop  <= RST_STOP;
         dow   <= RST_DOW;
         date  <= RST_DATE;
         mon   <= RST_MON;
         yr    <= RST_YEAR;
      end else if (load) begin
         hund  <= load_data[7:0];
         sec   <= {1'b0, load_data[14:8]};
         mins  <= {1'b0, load_data[22:16]};
         hmode <= load_data[31];
         hb5   <= load_data[29];
         hlow  <= load_data[28:24];
         stop  <= load_data[37];
         dow   <= {5'd0, load_data[34:32]};
         date  <= {2'b00, load_data[45:40]};
         mon   <= {3'b000, load_data[52:48]};
         yr    <= load_data[63:56];
      end else if (run) begin
         hund <= n_hund;
         if (c_sec) sec  <= n_sec;
         if (c_min) mins <= n_min;
         if (c_hr) begin
            hb5  <= n_hb5;
            hlow <= n_hlow;
         end
         if (c_day) begin
            dow  <= n_dow;
            date <= n_date;
         end
         if (c_mon) mon <= n_mon;
         if (c_yr)  yr  <= n_yr;
      end
   end

   bcd_byte_t rd [NREG];
   assign rd[0] = hund;
   assign rd[1] = sec;
   assign rd[2] = mins;
   assign rd[3] = {hmode, 1'b0, hb5, hlow};
   assign rd[4] = dow | {2'b00, stop, 5'd0};
   assign rd[5] = date;
   assign rd[6] = mon;
   assign rd[7] = yr;

   generate
      for (genvar k = 0; k < NREG; k++) begin : g_rd
         assign time_out[k*REG_W +: REG_W] = rd[k];
      end
   endgenerate

   logic unused_bus;
   assign unused_bus = (BUS_W == 0);
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk
   import bcd_calendar_pkg::*;
#(
   parameter int unsigned NREG  = CAL_NREG,
   parameter int unsigned REG_W = CAL_REG_W
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  tick,
   input logic                  load,
   input logic [NREG*REG_W-1:0] load_data,
   input logic [NREG*REG_W-1:0] time_out
);
   assert_zero_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (time_out & ~CAL_LIVE_MASK) == 64'd0);

   assert_load_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> time_out == ($past(load_data) & CAL_LIVE_MASK));

   assert_stop_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && time_out[37]) |=> $stable(time_out));

   assert_idle_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !tick) |=> $stable(time_out));

   assert_tick_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && !time_out[37]) |=> time_out != $past(time_out));

   assert_hund_digits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      time_out[3:0] <= 4'd9 && time_out[7:4] <= 4'd9);

   assert_hour12_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      time_out[31] |-> (time_out[28:24] >= 5'h01 && time_out[28:24] <= 5'h12));

   assert_hour24_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !time_out[31] |-> time_out[29:24] <= 6'h23);

   assert_dow_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      time_out[34:32] != 3'd0);
endmodule

bind bcd_calendar_core bcd_calendar_chk #(.NREG(NREG), .REG_W(REG_W)) u_chk (.*);

// File: tb/bcd_calendar_core_bench.sv
module bcd_calendar_core_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        load = 1'b0;
   logic [63:0] load_data = 64'd0;
   logic [63:0] time_out;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   typedef struct {
      logic [63:0] exp;
      string       req;
   } item_t;
   item_t sb_q[$];

   always #5 clk = ~clk;

   bcd_calendar_core u_bcd_calendar_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
      .load_data(load_data), .time_out(time_out)
   );

   function automatic logic [63:0] tv(input logic [7:0] hu, s, m, h, d, dt, mo, y);
      return {y, mo, dt, d, h, m, s, hu};
   endfunction

   task automatic check(input logic [63:0] exp, input string req);
      total++;
      if (time_out !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, time_out, exp);
      end
   endtask

   // driver: one stimulus cycle, expectation pushed to the scoreboard
   task automatic step(input bit ld, input logic [63:0] d, input bit tk,
                       input logic [63:0] e, input string req);
      item_t it;
      @(negedge clk);
      load = ld; load_data = d; tick = tk;
      it.exp = e; it.req = req;
      sb_q.push_back(it);
      @(negedge clk);
      load = 1'b0; tick = 1'b0;
   endtask

   task automatic ld_tick(input logic [63:0] start, input logic [63:0] e, input string req);
      step(1'b1, start, 1'b0, start, "R12");
      step(1'b0, 64'd0, 1'b1, e, req);
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.exp, it.req);
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got hung expected finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(64'h0001_0121_0000_0000, "R1");

      // stopped clock ignores ticks
      step(1'b0, 64'd0, 1'b1, 64'h0001_0121_0000_0000, "R10");

      step(1'b0 | 1'b1, tv(8'h00,8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00), 1'b0,
           tv(8'h00,8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00), "R12");
      step(1'b0, 64'd0, 1'b1, tv(8'h01,8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00), "R2");

      // load with tick in the same cycle: load wins
      step(1'b1, tv(8'h99,8'h59,8'h59,8'h23,8'h07,8'h31,8'h12,8'h99), 1'b1,
           tv(8'h99,8'h59,8'h59,8'h23,8'h07,8'h31,8'h12,8'h99), "R12");
      step(1'b0, 64'd0, 1'b1, tv(8'h00,8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00), "R14");
      step(1'b0, 64'd0, 1'b0, tv(8'h00,8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00), "R13");

      // junk in unused bits
      step(1'b1, tv(8'h00,8'h89,8'h85,8'h52,8'hDB,8'hC5,8'hE2,8'h24), 1'b0,
           tv(8'h00,8'h09,8'h05,8'h12,8'h03,8'h05,8'h02,8'h24), "R11");

      ld_tick(tv(8'h49,8'h10,8'h10,8'h10,8'h01,8'h10,8'h01,8'h00),
              tv(8'h50,8'h10,8'h10,8'h10,8'h01,8'h10,8'h01,8'h00), "R2");
      ld_tick(tv(8'h99,8'h59,8'h10,8'h10,8'h01,8'h10,8'h01,8'h00),
              tv(8'h00,8'h00,8'h11,8'h10,8'h01,8'h10,8'h01,8'h00), "R3");

      // month lengths and leap years
      ld_tick(tv(8'h99,8'h59,8'h59,8'h23,8'h02,8'h28,8'h02,8'h23),
              tv(8'h00,8'h00,8'h00,8'h00,8'h03,8'h01,8'h03,8'h23), "R7");
      ld_tick(tv(8'h99,8'h59,8'h59,8'h23,8'h02,8'h28,8'h02,8'h24),
              tv(8'h00,8'h00,8'h00,8'h00,8'h03,8'h29,8'h02,8'h24), "R8");
      ld_tick(tv(8'h99,8'h59,8'h59,8'h23,8'h03,8'h29,8'h02,8'h24),
              tv(8'h00,8'h00,8'h00,8'h00,8'h04,8'h01,8'h03,8'h24), "R8");
      ld_tick(tv(8'h99,8'h59,8'h59,8'h23,8'h02,8'h28,8'h02,8'h00),
              tv(8'h00,8'h00,8'h00,8'h00,8'h03,8'h29,8'h02,8'h00), "R8");
      ld_tick(tv(8'h99,8'h59,8'h59,8'h23,8'h01,8'h30,8'h04,8'h23),
              tv(8'h00,8'h00,8'h00,8'h00,8'h02,8'h01,8'h05,8'h23), "R7");
      ld_tick(tv(8'h99,8'h59,8'h59,8'h23,8'h01,8'h30,8'h01,8'h23),
              tv(8'h00,8'h00,8'h00,8'h00,8'h02,8'h31,8'h01,8'h23), "R7");
      ld_tick(tv(8'h99,8'h59,8'h59,8'h23,8'h06,8'h31,8'h12,8'h23),
              tv(8'h00,8'h00,8'h00,8'h00,8'h07,8'h01,8'h01,8'h24), "R9");
      ld_tick(tv(8'h99,8'h59,8'h59,8'h23,8'h07,8'h10,8'h06,8'h23),
              tv(8'h00,8'h00,8'h00,8'h00,8'h01,8'h11,8'h06,8'h23), "R6");

      // 12-hour mode
      ld_tick(tv(8'h99,8'h59,8'h59,8'h91,8'h01,8'h10,8'h06,8'h23),
              tv(8'h00,8'h00,8'h00,8'hB2,8'h01,8'h10,8'h06,8'h23), "R5");
      ld_tick(tv(8'h99,8'h59,8'h59,8'h92,8'h01,8'h10,8'h06,8'h23),
              tv(8'h00,8'h00,8'h00,8'h81,8'h01,8'h10,8'h06,8'h23), "R5");
      ld_tick(tv(8'h99,8'h59,8'h59,8'hB1,8'h01,8'h10,8'h06,8'h23),
              tv(8'h00,8'h00,8'h00,8'h92,8'h02,8'h11,8'h06,8'h23), "R5");
      ld_tick(tv(8'h99,8'h59,8'h59,8'hB2,8'h01,8'h10,8'h06,8'h23),
              tv(8'h00,8'h00,8'h00,8'hA1,8'h01,8'h10,8'h06,8'h23), "R5");
      ld_tick(tv(8'h99,8'h59,8'h59,8'h89,8'h01,8'h10,8'h06,8'h23),
              tv(8'h00,8'h00,8'h00,8'h90,8'h01,8'h10,8'h06,8'h23), "R5");

      // 24-hour digit steps
      ld_tick(tv(8'h99,8'h59,8'h59,8'h09,8'h01,8'h10,8'h06,8'h23),
              tv(8'h00,8'h00,8'h00,8'h10,8'h01,8'h10,8'h06,8'h23), "R4");
      ld_tick(tv(8'h99,8'h59,8'h59,8'h19,8'h01,8'h10,8'h06,8'h23),
              tv(8'h00,8'h00,8'h00,8'h20,8'h01,8'h10,8'h06,8'h23), "R4");

      // stop bit loaded, ticks ignored
      ld_tick(tv(8'h99,8'h59,8'h59,8'h23,8'h21,8'h10,8'h06,8'h23),
              tv(8'h99,8'h59,8'h59,8'h23,8'h21,8'h10,8'h06,8'h23), "R10");
      step(1'b0, 64'd0, 1'b1, tv(8'h99,8'h59,8'h59,8'h23,8'h21,8'h10,8'h06,8'h23), "R10");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule